// File: doc/BRIEF.md
# Remote Buffer Copy Port

This block lets a host move bytes between its register port and a 64 KB byte-addressed local buffer space, one data-port access at a time. The host first loads a 16-bit start address and a 16-bit byte count through byte-wide registers. It then writes a command whose operation field selects a read or a write, and streams the bytes through a single data-port register. In word mode each access carries two consecutive bytes, and the count may be odd, so the last access can be a single byte.

When the count reaches zero, the block sets a completion bit in the interrupt status register and drives it on `dmaDone` until the host clears it. Low addresses return a station-address image in which each MAC byte appears twice. A window of buffer RAM sits at a fixed base address. Every other address reads 0xFF.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset the command register reads 0x21 (stop bit 0 set, operation field bits 5:3 = 100), the status register at 0x07 reads 0x00, the current address at 0x08/0x09 reads 0x0000, and `dmaDone` is low.
- R2: A write to 0x08 loads address bits 7:0 and a write to 0x09 loads bits 15:8. Reading 0x08/0x09 returns the current address, which grows by one for each byte moved.
- R3: With operation 001 (read) active and word mode on (register 0x0E bit 0 = 1, bit 1 = 0), each read of port 0x10 returns the byte at the current address in bits 7:0 and the next byte in bits 15:8. The count then drops by two.
- R4: With operation 010 (write) active in word mode, each write to port 0x10 stores bits 7:0 at the current address and bits 15:8 at the following address.
- R5: With an odd count, the last word access moves one byte. A write discards bits 15:8, and a read returns 0 in the unused lane.
- R6: The access that brings the count to zero sets bit 6 of register 0x07 and `dmaDone`, and sets the command operation field to 100. Writing 0x07 with bit 6 set clears the bit; writing it with bit 6 clear leaves the bit set.
- R7: Writing operation 100 stops a transfer at once and keeps the current address and the remaining count. A later read or write command continues from there.
- R8: A data-port access while no matching read or write is active changes no memory and no address, and a read of the port then returns 0.
- R9: Addresses 0..31 form a read-only station image. Offsets 2i and 2i+1 (i = 0..5) hold MAC byte i, where byte 0 is the most significant byte of the MAC parameter. Offsets 12..31 read 0x00.
- R10: Addresses outside the image and outside the RAM window (base 16384, RAM_BYTES long) read 0xFF, and writes to them are dropped.
- R11: With register 0x0E bit 0 = 0 (byte mode), each access moves one byte in bits 7:0. A read returns 0 in bits 15:8.
- R12: With register 0x0E = 0x03, the byte at the current address travels in bits 15:8 and the next byte in bits 7:0.
- R13: A read or write command issued with a count of zero sets the completion bit without moving the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Register access this cycle |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 5 | Register offset |
| hostWdata | input | 16 | Write data (registers use bits 7:0) |
| hostRdata | output | 16 | Read data for the current access |
| dmaDone | output | 1 | Level copy of the completion bit |

## Verification
The copy path is exercised with three byte orders on the same stored data: word mode, byte mode and swapped word mode. This shows that lane selection follows the configuration and not the address. Even counts and odd counts separate two-byte steps from the final single-byte step, and a pre-filled byte next to an odd-length write exposes any spill into the discarded lane. Sweeps of the station image, of unmapped space and of idle port traffic check the region decode, the 0xFF default and dropped writes. An abort in mid-transfer followed by a resume checks that both the address and the count are held.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam logic [4:0] REG_CMD   = 5'h00;
  localparam logic [4:0] REG_ISR   = 5'h07;
  localparam logic [4:0] REG_SA_LO = 5'h08;
  localparam logic [4:0] REG_SA_HI = 5'h09;
  localparam logic [4:0] REG_CN_LO = 5'h0A;
  localparam logic [4:0] REG_CN_HI = 5'h0B;
  localparam logic [4:0] REG_DCFG  = 5'h0E;
  localparam logic [4:0] REG_PORT  = 5'h10;

  localparam logic [2:0] OP_READ  = 3'b001;
  localparam logic [2:0] OP_WRITE = 3'b010;
  localparam logic [2:0] OP_DONE  = 3'b100;

  typedef struct packed {
    logic       loadLo;
    logic       loadHi;
    logic [7:0] loadVal;
    logic       step;
    logic       twoBytes;
    logic       doWrite;
    logic       swap;
  } dpCtrl_t;
endpackage

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostSel,
  input  logic        hostWr,
  input  logic [4:0]  hostAddr,
  input  logic [15:0] hostWdata,
  input  logic [15:0] curAddr,
  input  logic [15:0] portRdData,
  output dpCtrl_t     dpCtrl,
  output logic [15:0] hostRdata,
  output logic        dmaDone
);
  logic [7:0]  cmdReg, dcfgReg;
  logic [15:0] remain;
  logic        active, rdc;

  logic wrAcc, rdAcc, portHit, xferHit, twoBytes, lastMove;
  logic [2:0] opNow;
  logic [15:0] moved;

  assign wrAcc    = hostSel && hostWr;
  assign rdAcc    = hostSel && !hostWr;
  assign opNow    = cmdReg[5:3];
  assign portHit  = hostSel && (hostAddr == REG_PORT);
  assign xferHit  = portHit && active &&
                    ((opNow == OP_READ && !hostWr) || (opNow == OP_WRITE && hostWr));
  assign twoBytes = dcfgReg[0] && (remain > 16'd1);
  assign moved    = twoBytes ? 16'd2 : 16'd1;
  assign lastMove = xferHit && (remain == moved);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg  <= 8'h21;
      dcfgReg <= 8'h00;
      remain  <= 16'h0000;
      active  <= 1'b0;
      rdc     <= 1'b0;
    end else begin
      if (wrAcc) begin
        case (hostAddr)
          REG_CMD: begin
            cmdReg <= hostWdata[7:0];
            if (hostWdata[5:3] == OP_READ || hostWdata[5:3] == OP_WRITE) begin
              active <= (remain != 16'd0);
              if (remain == 16'd0) rdc <= 1'b1;
            end else begin
              active <= 1'b0;
            end
          end
          REG_ISR:   if (hostWdata[6]) rdc <= 1'b0;
          REG_CN_LO: remain[7:0]  <= hostWdata[7:0];
          REG_CN_HI: remain[15:8] <= hostWdata[7:0];
          REG_DCFG:  dcfgReg <= hostWdata[7:0];
          default: ;
        endcase
      end
      if (xferHit) begin
        remain <= remain - moved;
        if (lastMove) begin
          active       <= 1'b0;
          rdc          <= 1'b1;
          cmdReg[5:3]  <= OP_DONE;
        end
      end
    end
  end

  always_comb begin
    dpCtrl          = '0;
    dpCtrl.loadLo   = wrAcc && (hostAddr == REG_SA_LO);
    dpCtrl.loadHi   = wrAcc && (hostAddr == REG_SA_HI);
    dpCtrl.loadVal  = hostWdata[7:0];
    dpCtrl.step     = xferHit;
    dpCtrl.twoBytes = twoBytes;
    dpCtrl.doWrite  = xferHit && hostWr;
    dpCtrl.swap     = dcfgReg[0] && dcfgReg[1];
  end

  always_comb begin
    hostRdata = 16'h0000;
    if (rdAcc) begin
      case (hostAddr)
        REG_CMD:   hostRdata = {8'h00, cmdReg};
        REG_ISR:   hostRdata = {9'h000, rdc, 6'h00};
        REG_SA_LO: hostRdata = {8'h00, curAddr[7:0]};
        REG_SA_HI: hostRdata = {8'h00, curAddr[15:8]};
        REG_PORT:  hostRdata = xferHit ? portRdData : 16'h0000;
        default:   hostRdata = 16'h0000;
      endcase
    end
  end

  assign dmaDone = rdc;

  AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    active |-> remain != 16'd0);  // R5
  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdc) |-> !active);  // R6
  AST_RDC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && hostAddr == REG_ISR && hostWdata[6]) |=> !rdc);  // R6
  AST_IDLE_PORT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && portHit && !active) |-> hostRdata == 16'h0000);  // R8
endmodule

// File: rtl/rdma_datapath.sv
module rdma_datapath
  import rdma_pkg::*;
#(
  parameter int          RAM_BASE  = 16384,
  parameter int          RAM_BYTES = 2048,
  parameter logic [47:0] MAC       = 48'h02_00_00_00_00_01
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpCtrl_t     dpCtrl,
  input  logic [15:0] hostWdata,
  output logic [15:0] curAddr,
  output logic [15:0] portRdData
);
  localparam int          RAM_AW = $clog2(RAM_BYTES);
  localparam logic [16:0] RAM_LO = 17'(RAM_BASE);
  localparam logic [16:0] RAM_HI = 17'(RAM_BASE + RAM_BYTES);
  localparam int          MAC_BYTES = 6;

  logic [7:0] ram [RAM_BYTES];

  logic [15:0]       laneAddr [2];
  logic              inRam    [2];
  logic [RAM_AW-1:0] ramIdx   [2];
  logic [7:0]        byteVal  [2];
  logic [7:0]        wrByte   [2];
  logic              laneUsed [2];

  for (genvar k = 0; k < 2; k++) begin : g_lane
    logic [3:0]  promIdx;
    logic [15:0] offs;
    assign laneAddr[k] = curAddr + 16'(k);
    assign offs        = laneAddr[k] - 16'(RAM_BASE);
    assign inRam[k]    = ({1'b0, laneAddr[k]} >= RAM_LO) && ({1'b0, laneAddr[k]} < RAM_HI);
    assign ramIdx[k]   = offs[RAM_AW-1:0];
    assign promIdx     = laneAddr[k][4:1];
    assign laneUsed[k] = (k == 0) || dpCtrl.twoBytes;
    assign wrByte[k]   = (dpCtrl.swap ^ (k == 1)) ? hostWdata[15:8] : hostWdata[7:0];
    always_comb begin
      if (laneAddr[k] < 16'd32)
        byteVal[k] = (int'(promIdx) < MAC_BYTES) ? MAC[47 - 8*int'(promIdx) -: 8] : 8'h00;
      else if (inRam[k])
        byteVal[k] = ram[ramIdx[k]];
      else
        byteVal[k] = 8'hFF;
    end
  end

  always_comb begin
    logic [7:0] b0, b1;
    b0 = byteVal[0];
    b1 = laneUsed[1] ? byteVal[1] : 8'h00;
    portRdData = dpCtrl.swap ? {b0, b1} : {b1, b0};
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < 2; k++)
      if (dpCtrl.doWrite && laneUsed[k] && inRam[k])
        ram[ramIdx[k]] <= wrByte[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN) curAddr <= 16'h0000;
    else if (dpCtrl.step) curAddr <= curAddr + (dpCtrl.twoBytes ? 16'd2 : 16'd1);
    else begin
      if (dpCtrl.loadLo) curAddr[7:0]  <= dpCtrl.loadVal;
      if (dpCtrl.loadHi) curAddr[15:8] <= dpCtrl.loadVal;
    end
  end

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!dpCtrl.step && !dpCtrl.loadLo && !dpCtrl.loadHi) |=> $stable(curAddr));  // R7
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
  import rdma_pkg::*;
#(
  parameter int          RAM_BASE  = 16384,
  parameter int          RAM_BYTES = 2048,
  parameter logic [47:0] MAC       = 48'h02_00_00_00_00_01
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostSel,
  input  logic        hostWr,
  input  logic [4:0]  hostAddr,
  input  logic [15:0] hostWdata,
  output logic [15:0] hostRdata,
  output logic        dmaDone
);
  dpCtrl_t     dpCtrl;
  logic [15:0] curAddr, portRdData;

  rdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .curAddr(curAddr),
    .portRdData(portRdData), .dpCtrl(dpCtrl), .hostRdata(hostRdata),
    .dmaDone(dmaDone)
  );

  rdma_datapath #(.RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES), .MAC(MAC)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .hostWdata(hostWdata),
    .curAddr(curAddr), .portRdData(portRdData)
  );
endmodule

// File: tb/rdma_port_engine_tb.sv
module rdma_port_engine_tb_top;
  localparam int          RAM_BASE  = 16384;
  localparam int          RAM_BYTES = 2048;
  localparam logic [47:0] MAC       = 48'h02_A1_B2_C3_D4_E5;

  logic clk = 1'b0, rstN = 1'b0, hostSel = 1'b0, hostWr = 1'b0;
  logic [4:0]  hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic        dmaDone;

  always #10 clk = ~clk;

  rdma_port_engine #(.RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES), .MAC(MAC)) dut_i (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata), .dmaDone(dmaDone)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural reference state
  byte unsigned mMem [int];
  int mCmd = 'h21, mDcfg = 0, mAddr = 0, mCnt = 0;
  bit mAct = 0, mRdc = 0;

  function automatic int memRd(int a);
    a = a & 'hFFFF;
    if (a < 32) return ((a >> 1) < 6) ? int'(MAC >> (40 - 8 * (a >> 1))) & 'hFF : 0;
    if (a >= RAM_BASE && a < RAM_BASE + RAM_BYTES) return mMem.exists(a) ? int'(mMem[a]) : 0;
    return 'hFF;
  endfunction

  function automatic void memWr(int a, int v);
    a = a & 'hFFFF;
    if (a >= RAM_BASE && a < RAM_BASE + RAM_BYTES) mMem[a] = byte'(v);
  endfunction

  function automatic int opOf(); return (mCmd >> 3) & 7; endfunction
  function automatic int movedNow(); return ((mDcfg & 1) && mCnt > 1) ? 2 : 1; endfunction
  function automatic bit swapOn(); return (mDcfg & 3) == 3; endfunction

  function automatic int expectRead(int a);
    int b0, b1;
    case (a)
      'h00: return mCmd;
      'h07: return mRdc ? 'h40 : 0;
      'h08: return mAddr & 'hFF;
      'h09: return (mAddr >> 8) & 'hFF;
      'h10: begin
        if (!(mAct && opOf() == 1)) return 0;
        b0 = memRd(mAddr);
        b1 = (movedNow() == 2) ? memRd(mAddr + 1) : 0;
        return swapOn() ? (b0 << 8) | b1 : (b1 << 8) | b0;
      end
      default: return 0;
    endcase
  endfunction

  function automatic void modelStep(bit wr, int a, int wd);
    int mv;
    if (wr) begin
      case (a)
        'h00: begin
          mCmd = wd & 'hFF;
          if (opOf() == 1 || opOf() == 2) begin
            if (mCnt == 0) mRdc = 1;
            mAct = (mCnt != 0);
          end else mAct = 0;
        end
        'h07: if (wd & 'h40) mRdc = 0;
        'h08: mAddr = (mAddr & 'hFF00) | (wd & 'hFF);
        'h09: mAddr = (mAddr & 'h00FF) | ((wd & 'hFF) << 8);
        'h0A: mCnt = (mCnt & 'hFF00) | (wd & 'hFF);
        'h0B: mCnt = (mCnt & 'h00FF) | ((wd & 'hFF) << 8);
        'h0E: mDcfg = wd & 'hFF;
        default: ;
      endcase
    end
    if (a == 'h10 && mAct && ((opOf() == 1 && !wr) || (opOf() == 2 && wr))) begin
      mv = movedNow();
      if (wr) begin
        memWr(mAddr, swapOn() ? (wd >> 8) : wd);
        if (mv == 2) memWr(mAddr + 1, swapOn() ? wd : (wd >> 8));
      end
      mAddr = (mAddr + mv) & 'hFFFF;
      mCnt  = mCnt - mv;
      if (mCnt == 0) begin
        mAct = 0; mRdc = 1; mCmd = (mCmd & 'hC7) | 'h20;
      end
    end
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%04h expected=%04h", tag, act, exp);
    end
  endtask

  task automatic access(bit wr, int a, int wd, string tag);
    int exp;
    @(negedge clk);
    hostSel = 1'b1; hostWr = wr; hostAddr = 5'(a); hostWdata = 16'(wd);
    exp = expectRead(a);
    #2;
    if (!wr) check(tag, int'(hostRdata), exp);
    @(posedge clk);
    modelStep(wr, a, wd);
    #1 hostSel = 1'b0; hostWr = 1'b0;
  endtask

  task automatic setup(int addr, int cnt, int cmd, string tag);
    access(1, 'h08, addr & 'hFF, tag);
    access(1, 'h09, addr >> 8, tag);
    access(1, 'h0A, cnt & 'hFF, tag);
    access(1, 'h0B, cnt >> 8, tag);
    access(1, 'h00, cmd, tag);
  endtask

  // done line compared against the model every cycle (R6)
  always @(negedge clk) if (rstN && !finished) check("R6 dmaDone", int'(dmaDone), int'(mRdc));

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    access(0, 'h00, 0, "R1 cmd");
    access(0, 'h07, 0, "R1 isr");
    access(0, 'h08, 0, "R1 addr lo");
    access(0, 'h09, 0, "R1 addr hi");
    // R4 word write, R6 completion
    access(1, 'h0E, 'h01, "cfg");
    setup('h4000, 6, 'h12, "R4 setup");
    access(1, 'h10, 'h2211, "R4"); access(1, 'h10, 'h4433, "R4"); access(1, 'h10, 'h6655, "R4");
    access(0, 'h00, 0, "R6 op done");
    access(0, 'h07, 0, "R6 isr set");
    access(0, 'h08, 0, "R2 addr lo"); access(0, 'h09, 0, "R2 addr hi");
    access(1, 'h07, 'h00, "R6"); access(0, 'h07, 0, "R6 no clear on 0");
    access(1, 'h07, 'h40, "R6"); access(0, 'h07, 0, "R6 cleared");
    // R8 idle port write and read
    access(1, 'h10, 'h9999, "R8"); access(0, 'h10, 0, "R8 idle read zero");
    access(0, 'h08, 0, "R8 addr unchanged");
    // R3 word read
    setup('h4000, 6, 'h0A, "R3 setup");
    for (int i = 0; i < 3; i++) access(0, 'h10, 0, "R3 word read");
    access(1, 'h07, 'h40, "clr");
    // R5 odd count
    setup('h4010, 4, 'h12, "R5 setup");
    access(1, 'h10, 'h1111, "R5"); access(1, 'h10, 'h2222, "R5");
    setup('h4010, 3, 'h12, "R5 setup");
    access(1, 'h10, 'hBBAA, "R5"); access(1, 'h10, 'hDDCC, "R5");
    access(0, 'h08, 0, "R5 addr after odd");
    setup('h4010, 4, 'h0A, "R5 setup");
    access(0, 'h10, 0, "R5 readback"); access(0, 'h10, 0, "R5 high byte kept");
    setup('h4010, 3, 'h0A, "R5 setup");
    access(0, 'h10, 0, "R5 odd read"); access(0, 'h10, 0, "R5 odd lane zero");
    // R11 byte mode
    access(1, 'h0E, 'h00, "cfg");
    setup('h4000, 2, 'h0A, "R11 setup");
    access(0, 'h10, 0, "R11 byte"); access(0, 'h10, 0, "R11 byte");
    access(0, 'h08, 0, "R11 addr");
    // R12 swapped order
    access(1, 'h0E, 'h03, "cfg");
    setup('h4000, 4, 'h0A, "R12 setup");
    access(0, 'h10, 0, "R12 swap"); access(0, 'h10, 0, "R12 swap");
    // R9 station image
    access(1, 'h0E, 'h01, "cfg");
    setup(0, 2, 'h12, "R9 setup"); access(1, 'h10, 'hFFFF, "R9 write ignored");
    setup(0, 32, 'h0A, "R9 setup");
    for (int i = 0; i < 16; i++) access(0, 'h10, 0, "R9 image");
    // R10 unmapped
    setup('h8000, 2, 'h12, "R10 setup"); access(1, 'h10, 'h1234, "R10");
    setup('h8000, 2, 'h0A, "R10 setup"); access(0, 'h10, 0, "R10 reads FF");
    setup('h0100, 2, 'h0A, "R10 setup"); access(0, 'h10, 0, "R10 low gap FF");
    setup(RAM_BASE + RAM_BYTES - 1, 2, 'h0A, "R10 setup"); access(0, 'h10, 0, "R10 ram edge");
    access(1, 'h07, 'h40, "clr");
    // R7 abort and resume
    setup('h4000, 6, 'h0A, "R7 setup");
    access(0, 'h10, 0, "R7 first");
    access(1, 'h00, 'h22, "R7 abort");
    access(0, 'h08, 0, "R7 addr held");
    access(0, 'h10, 0, "R7 port after abort");
    access(0, 'h07, 0, "R7 no done");
    access(1, 'h00, 'h0A, "R7 resume");
    access(0, 'h10, 0, "R7 resumed"); access(0, 'h10, 0, "R7 resumed");
    access(0, 'h07, 0, "R7 done after resume");
    access(1, 'h07, 'h40, "clr");
    // R13 zero count
    setup('h4020, 0, 'h0A, "R13 setup");
    access(0, 'h07, 0, "R13 done");
    access(0, 'h08, 0, "R13 addr");
    access(0, 'h10, 0, "R13 port idle");
    repeat (2) @(negedge clk);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule